// File: doc/BRIEF.md
# Compare and Step Arithmetic Unit

This unit carries out two register-level operations for a processor datapath. The first is a compare. It subtracts the second operand from the first, records the outcome in five status flags (carry/borrow, signed overflow, nibble borrow, negative and zero) and discards the difference, so the register file is never written. The second is a step operation. It increments or decrements a byte, word or dword operand by 1, 2 or 4, which suits pointer advance and loop counting. The stepped value is returned together with a one-cycle write enable.

The decoder supplies an issue strobe, an operation code, a width code, both operands and a step code. It samples the outputs one clock later. The flag registers keep their values between operations. Step operations rewrite only the zero and negative flags, so a compare's carry, overflow and nibble borrow remain valid for a later conditional branch.

Top module: `cmpstep_unit`

## Requirements
- R1: After reset, `result` is zero and `wr_en`, `cy`, `ov`, `ac`, `neg` and `zero` are all low.
- R2: A compare (`op` = 00) forms the first operand minus the second within the selected width. `zero` is set exactly when the two truncated operands are equal. `neg` takes the difference's top bit, which is bit 7, 15 or 31 depending on the width.
- R3: On a compare, `cy` is set exactly when the truncated first operand is below the truncated second operand as unsigned numbers.
- R4: On a compare, `ov` is set exactly when the operands have different sign bits and the difference's sign bit differs from the first operand's sign bit.
- R5: On a compare, `ac` is set exactly when bits 3..0 of the first operand are below bits 3..0 of the second operand.
- R6: A compare leaves `wr_en` low in the following cycle and leaves `result` unchanged.
- R7: Increment (`op` = 01) adds the step and decrement (`op` = 10) subtracts it, modulo 2 to the power of the width. Bits above the width read zero in `result`, and `wr_en` is high for the single following cycle.
- R8: Step code 00 selects 1, 01 selects 2, 10 selects 4, and the reserved code 11 selects 1.
- R9: Increment and decrement set `zero` and `neg` from the new result and leave `cy`, `ov` and `ac` unchanged.
- R10: Width code 00 selects byte, 01 selects word, 10 selects dword, and 11 acts as dword. Operand bits above the selected width do not affect any output.
- R11: When `go` is low, or when `op` is the unused code 11, all flags and `result` hold their values and `wr_en` is low.
- R12: Every output reflects an issued operation on the first clock edge after issue and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Issue strobe for this cycle's operation |
| op | input | 2 | 00 compare, 01 increment, 10 decrement, 11 none |
| width | input | 2 | 00 byte, 01 word, 10/11 dword |
| opa | input | W | First operand, or the value to step |
| opb | input | W | Second operand (compare only) |
| step | input | 2 | Step code: 00→1, 01→2, 10→4, 11→1 |
| result | output | W | Stepped value, zero-extended above the width |
| wr_en | output | 1 | High for one cycle after a step operation |
| cy | output | 1 | Borrow from the top bit |
| ov | output | 1 | Signed overflow of the subtraction |
| ac | output | 1 | Borrow out of bit 3 |
| neg | output | 1 | Top bit of the last difference or stepped value |
| zero | output | 1 | Last difference or stepped value was zero |

## Verification
A compare and a step can follow each other in back-to-back cycles. Both then act on the same flag registers, and each must leave the other's flags in the right state. The bench interleaves the two: a compare sets `cy`, `ov` and `ac`, then the immediately following increments and decrements must keep those three bits while they rewrite `zero` and `neg`. Each cycle's outputs are compared against a running arithmetic model that holds the flag state, so a step that disturbs the compare's carry, or a compare that writes a result, shows up in the cycle after it happens.

// File: rtl/cmpstep_unit.sv
module cmpstep_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [1:0]   op,
  input  logic [1:0]   width,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [1:0]   step,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic         cy,
  output logic         ov,
  output logic         ac,
  output logic         neg,
  output logic         zero
);
  localparam int HW = W / 2;
  localparam int QW = W / 4;
  localparam logic [1:0] OP_CMP = 2'b00;
  localparam logic [1:0] OP_INC = 2'b01;
  localparam logic [1:0] OP_DEC = 2'b10;

  logic [W-1:0] mask, am, bm, diff, stepv, stepped;
  int unsigned  top;
  logic         sa, sb, sd, sr;

  always_comb begin
    case (width)
      2'b00:   begin mask = {{(W-QW){1'b0}}, {QW{1'b1}}}; top = QW - 1; end
      2'b01:   begin mask = {{(W-HW){1'b0}}, {HW{1'b1}}}; top = HW - 1; end
      default: begin mask = '1;                           top = W - 1;  end
    endcase
  end

  assign am      = opa & mask;
  assign bm      = opb & mask;
  assign diff    = (am - bm) & mask;
  assign stepv   = (step == 2'b01) ? W'(2) : (step == 2'b10) ? W'(4) : W'(1);
  assign stepped = ((op == OP_DEC) ? am - stepv : am + stepv) & mask;

  assign sa = am[top];
  assign sb = bm[top];
  assign sd = diff[top];
  assign sr = stepped[top];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      wr_en  <= 1'b0;
      cy     <= 1'b0;
      ov     <= 1'b0;
      ac     <= 1'b0;
      neg    <= 1'b0;
      zero   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (go && op == OP_CMP) begin
        cy   <= am < bm;
        ov   <= (sa != sb) && (sd != sa);
        ac   <= am[3:0] < bm[3:0];
        neg  <= sd;
        zero <= diff == '0;
      end else if (go && (op == OP_INC || op == OP_DEC)) begin
        result <= stepped;
        wr_en  <= 1'b1;
        neg    <= sr;
        zero   <= stepped == '0;
      end
    end
  end
endmodule

// File: rtl/cmpstep_unit_chk.sv
module cmpstep_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         go,
  input logic [1:0]   op,
  input logic [1:0]   width,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [W-1:0] result,
  input logic         wr_en,
  input logic         cy,
  input logic         ov,
  input logic         ac,
  input logic         neg,
  input logic         zero
);
  localparam int QW = W / 4;
  localparam int HW = W / 2;
  logic [W-1:0] m;
  logic is_step, is_cmp;

  always_comb begin
    case (width)
      2'b00:   m = {{(W-QW){1'b0}}, {QW{1'b1}}};
      2'b01:   m = {{(W-HW){1'b0}}, {HW{1'b1}}};
      default: m = '1;
    endcase
  end
  assign is_step = go && (op == 2'b01 || op == 2'b10);
  assign is_cmp  = go && op == 2'b00;

  a_r6_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmp |=> !wr_en && $stable(result));
  a_r7_step_writes: assert property (@(posedge clk) disable iff (!rst_n)
    is_step |=> wr_en);
  a_r9_keep_borrow_flags: assert property (@(posedge clk) disable iff (!rst_n)
    is_step |=> $stable(cy) && $stable(ov) && $stable(ac));
  a_r9_zero_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
    is_step |=> zero == (result == '0));
  a_r10_byte_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    is_step && width == 2'b00 |=> result[W-1:QW] == '0);
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_cmp || is_step) |=> !wr_en && $stable(result) && $stable(cy) &&
      $stable(ov) && $stable(ac) && $stable(neg) && $stable(zero));
  a_r2_equal_sets_zero: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmp && ((opa ^ opb) & m) == '0 |=> zero && !neg && !cy && !ov && !ac);
endmodule

bind cmpstep_unit cmpstep_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .op(op), .width(width),
  .opa(opa), .opb(opb), .result(result), .wr_en(wr_en),
  .cy(cy), .ov(ov), .ac(ac), .neg(neg), .zero(zero)
);

// File: tb/cmpstep_unit_bench.sv
module cmpstep_unit_bench;
  localparam int W = 32;
  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
  logic [1:0] op = '0, width = '0, step = '0;
  logic [W-1:0] opa = '0, opb = '0;
  logic [W-1:0] result;
  logic wr_en, cy, ov, ac, neg, zero;

  cmpstep_unit #(.W(W)) u_cmpstep_unit (
    .clk(clk), .rst_n(rst_n), .go(go), .op(op), .width(width),
    .opa(opa), .opb(opb), .step(step), .result(result), .wr_en(wr_en),
    .cy(cy), .ov(ov), .ac(ac), .neg(neg), .zero(zero)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [W-1:0] e_res = '0;
  logic e_we = 0, e_cy = 0, e_ov = 0, e_ac = 0, e_n = 0, e_z = 0;

  task automatic check(input string tag);
    checks++;
    if ({result, wr_en, cy, ov, ac, neg, zero} !== {e_res, e_we, e_cy, e_ov, e_ac, e_n, e_z}) begin
      fails++;
      $display("FAIL %s: got res=%h we=%b cy=%b ov=%b ac=%b n=%b z=%b, expected res=%h we=%b cy=%b ov=%b ac=%b n=%b z=%b",
               tag, result, wr_en, cy, ov, ac, neg, zero, e_res, e_we, e_cy, e_ov, e_ac, e_n, e_z);
    end
  endtask

  task automatic model(input logic g, input logic [1:0] o, w, s, input logic [W-1:0] a, b);
    int wb;
    longint unsigned m, ua, ub, d, r, st;
    wb = (w == 2'b00) ? 8 : (w == 2'b01) ? 16 : 32;
    m  = (64'd1 << wb) - 1;
    ua = 64'(a) & m;
    ub = 64'(b) & m;
    e_we = 1'b0;
    if (g && o == 2'b00) begin
      d    = (ua - ub) & m;
      e_cy = ua < ub;
      e_ac = (ua & 15) < (ub & 15);
      e_n  = d[wb-1];
      e_z  = d == 0;
      e_ov = (ua[wb-1] != ub[wb-1]) && (d[wb-1] != ua[wb-1]);
    end else if (g && (o == 2'b01 || o == 2'b10)) begin
      st    = (s == 2'b01) ? 2 : (s == 2'b10) ? 4 : 1;
      r     = ((o == 2'b01) ? ua + st : ua - st) & m;
      e_res = W'(r);
      e_we  = 1'b1;
      e_n   = r[wb-1];
      e_z   = r == 0;
    end
  endtask

  // Called at a falling edge; drives one operation and checks it at the next falling edge (R12).
  task automatic issue(input logic g, input logic [1:0] o, w, s,
                       input logic [W-1:0] a, b, input string tag);
    go = g; op = o; width = w; step = s; opa = a; opb = b;
    model(g, o, w, s, a, b);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset state");

    // R2 R3 R4 R5: exhaustive byte compare, upper bits garbage (R10)
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        issue(1'b1, 2'b00, 2'b00, 2'b00, {24'hA5C3_5A, 8'(i)}, {24'h3C_96F0, 8'(j)},
              "R2 R3 R4 R5 R6 R10 byte compare");

    // word and dword compares, corners then random
    issue(1'b1, 2'b00, 2'b01, 2'b00, 32'h0000_8000, 32'h0000_0001, "R4 word overflow");
    issue(1'b1, 2'b00, 2'b10, 2'b00, 32'h8000_0000, 32'h0000_0001, "R4 dword overflow");
    issue(1'b1, 2'b00, 2'b11, 2'b00, 32'h0000_0000, 32'hFFFF_FFFF, "R3 R10 width 11 as dword");
    issue(1'b1, 2'b00, 2'b01, 2'b00, 32'hFFFF_1234, 32'h0000_1234, "R2 R10 word equal");
    for (int k = 0; k < 4000; k++)
      issue(1'b1, 2'b00, 2'(k % 4), 2'b00, $urandom, $urandom, "R2 R3 R4 R5 wide compare");

    // R7 R8: byte step sweep, every value, step code and direction
    for (int v = 0; v < 256; v++)
      for (int s = 0; s < 4; s++) begin
        issue(1'b1, 2'b01, 2'b00, 2'(s), {24'hFFFFFF, 8'(v)}, '0, "R7 R8 R10 byte increment");
        issue(1'b1, 2'b10, 2'b00, 2'(s), {24'h123456, 8'(v)}, '0, "R7 R8 R10 byte decrement");
      end

    // wrap corners at word and dword
    issue(1'b1, 2'b01, 2'b01, 2'b10, 32'h0000_FFFC, '0, "R7 word wrap up");
    issue(1'b1, 2'b10, 2'b01, 2'b01, 32'h0000_0001, '0, "R7 word wrap down");
    issue(1'b1, 2'b01, 2'b10, 2'b00, 32'hFFFF_FFFF, '0, "R7 dword wrap up");
    issue(1'b1, 2'b10, 2'b10, 2'b10, 32'h0000_0002, '0, "R7 dword wrap down");

    // compare then steps back to back: steps must keep cy/ov/ac (R9)
    for (int k = 0; k < 2000; k++) begin
      issue(1'b1, 2'b00, 2'(k % 3), 2'b00, $urandom, $urandom, "R3 R4 R5 compare before step");
      issue(1'b1, 2'(1 + (k % 2)), 2'(k % 4), 2'($urandom % 4), $urandom, $urandom, "R9 step keeps borrow flags");
      issue(1'b1, 2'b01, 2'b10, 2'b00, 32'hFFFF_FFFF, '0, "R9 step to zero");
    end

    // R11: idle or unused op changes nothing
    issue(1'b1, 2'b10, 2'b00, 2'b00, 32'h0000_0081, '0, "R7 setup before idle");
    issue(1'b0, 2'b00, 2'b01, 2'b00, 32'h1, 32'h2, "R11 go low with compare op");
    issue(1'b0, 2'b01, 2'b01, 2'b00, 32'h1, 32'h2, "R11 go low with step op");
    issue(1'b1, 2'b11, 2'b10, 2'b10, 32'h5, 32'h9, "R11 unused op code");
    issue(1'b1, 2'b00, 2'b00, 2'b00, 32'h10, 32'h10, "R6 compare keeps result");
    issue(1'b0, 2'b00, 2'b00, 2'b00, '0, '0, "R7 write enable drops");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule